// File: doc/BRIEF.md
# Memory Replay-Protection Hash Unit

This unit guards a small external memory region against replay. It sits beside a write-back cache and keeps one digest of the whole region in a register that has no port. Each time the user writes a word into the cache, the unit walks the region. In that walk it checks the current contents against the stored digest. It also builds the new digest with the written value put in place of the word at its address. The update is done at cache-write time and not at flush time. A value that is flushed and later brought back under a newer write therefore still shows up as stale.

Every fill from memory into the cache causes the same check over the whole region. During a walk the unit raises `busy`, and the cache holds its requests until `busy` falls. The walk reads the coherent view of each word through `viewAddr`/`viewData`. That view is the cached copy when the word is resident and the memory word otherwise. A mismatch sets a sticky replay exception. After that the unit accepts no further requests until reset. The digest is a rotate-XOR fold. It is not cryptographic.

Top module: `replay_guard`

## Requirements
- R1: After reset, `busy` and `replayErr` are 0.
- R2: A request seen on `wrReq` or `fillReq` while idle and error-free is taken at that clock edge. `busy` is then high for exactly WORDS+1 cycles. If both requests are high at once, only the write is taken.
- R3: During a walk `viewAddr` steps through 0, 1, … WORDS-1, one word per cycle.
- R4: The digest fold starts from 0. For each word in address order it computes acc = rotate-left-by-1(acc) XOR code. The code is the word's view value if that word was written by the user since reset, and EMPTY_CODE (default 16'hA5C3) otherwise. The digest after reset is the fold with every word empty.
- R5: A fill whose walk folds to the stored digest raises no exception. The contents of words never written have no effect.
- R6: A fill whose walk does not match the stored digest sets `replayErr`.
- R7: A write checks the region in the same walk before it commits the new digest. On a mismatch it sets `replayErr` and commits nothing.
- R8: The sequence write A, flush, write B, drop the cached B so that the view returns A, is detected as a replay on the next fill.
- R9: `flushReq` starts no walk and leaves the digest unchanged.
- R10: A request presented while `busy` is high is dropped. It starts no walk and does not update the digest.
- R11: `replayErr` stays set until reset. While it is set, requests start no walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrReq | input | 1 | User write into the cache |
| wrAddr | input | $clog2(WORDS) | Word address of the write |
| wrData | input | DATA_W | Value being written |
| fillReq | input | 1 | Fill from memory into the cache |
| flushReq | input | 1 | Line flushed to memory (no digest effect) |
| busy | output | 1 | Walk in progress; cache must stall |
| viewAddr | output | $clog2(WORDS) | Word being read by the walk |
| viewData | input | DATA_W | Coherent value of word `viewAddr`, same cycle |
| replayErr | output | 1 | Sticky replay exception |

## Verification
The digest and the written-word map are hidden, so a wrong internal state shows up only as a false or missing `replayErr`. That happens at the end of the next walk, WORDS+1 cycles after a fill or write is taken. A digest committed with a bad value, or one not committed after a write, therefore gives a false exception on the very next fill of an untouched region. A skipped or misplaced walk shows at once in the length of `busy` and in the `viewAddr` sequence. The directed scenarios pair each tamper with a clean control run, so that both missing and false exceptions are caught.

// File: rtl/replay_guard_pkg.sv
package replay_guard_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_FINISH} walkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic start;    // latch operation, clear accumulators
    logic isWrite;  // operation taken is a write
    logic step;     // fold word at current index
    logic finish;   // compare and commit
  } walkCtl_t;
endpackage

// File: rtl/replay_guard_ctrl.sv
module replay_guard_ctrl
  import replay_guard_pkg::*;
#(
  parameter int WORDS = 8,
  parameter int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrReq,
  input  logic             fillReq,
  input  logic             flushReq,
  input  logic             errIn,
  output walkCtl_t         ctl,
  output logic [IDX_W-1:0] idx,
  output logic             busy
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  walkState_e state;

  always_comb begin
    ctl         = '0;
    ctl.start   = (state == ST_IDLE) && !errIn && (wrReq || fillReq);
    ctl.isWrite = wrReq;
    ctl.step    = (state == ST_WALK);
    ctl.finish  = (state == ST_FINISH);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (ctl.start) begin
          state <= ST_WALK;
          idx   <= '0;
        end
        ST_WALK: if (idx == LAST_IDX) state <= ST_FINISH;
                 else idx <= idx + 1'b1;
        ST_FINISH: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  take_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !errIn && (wrReq || fillReq)) |=> (busy && idx == '0));

  // R3
  walk_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WALK && idx != LAST_IDX) |=> (state == ST_WALK && idx == $past(idx) + 1'b1));

  // R9
  flush_no_walk_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && flushReq && !wrReq && !fillReq) |=> !busy);

  // R11
  halted_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && errIn) |=> !busy);
endmodule

// File: rtl/replay_guard_dp.sv
module replay_guard_dp
  import replay_guard_pkg::*;
#(
  parameter int              WORDS      = 8,
  parameter int              DATA_W     = 16,
  parameter logic [DATA_W-1:0] EMPTY_CODE = 16'hA5C3,
  parameter int              IDX_W      = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkCtl_t          ctl,
  input  logic [IDX_W-1:0]  idx,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] viewData,
  output logic              replayErr
);
  function automatic logic [DATA_W-1:0] foldStep(logic [DATA_W-1:0] acc, logic [DATA_W-1:0] w);
    return {acc[DATA_W-2:0], acc[DATA_W-1]} ^ w;
  endfunction

  function automatic logic [DATA_W-1:0] emptyFold();
    logic [DATA_W-1:0] acc = '0;
    for (int i = 0; i < WORDS; i++) acc = foldStep(acc, EMPTY_CODE);
    return acc;
  endfunction

  localparam logic [DATA_W-1:0] RESET_DIGEST = emptyFold();

  logic [DATA_W-1:0] digest;       // no port reaches this
  logic [WORDS-1:0]  written;
  logic [DATA_W-1:0] checkAcc, nextAcc;
  logic [IDX_W-1:0]  opAddr;
  logic [DATA_W-1:0] opData;
  logic              opWrite;
  logic [DATA_W-1:0] curCode, newCode;

  always_comb begin
    curCode = written[idx] ? viewData : EMPTY_CODE;
    newCode = (opWrite && idx == opAddr) ? opData : curCode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      digest    <= RESET_DIGEST;
      written   <= '0;
      checkAcc  <= '0;
      nextAcc   <= '0;
      opAddr    <= '0;
      opData    <= '0;
      opWrite   <= 1'b0;
      replayErr <= 1'b0;
    end else begin
      if (ctl.start) begin
        checkAcc <= '0;
        nextAcc  <= '0;
        opAddr   <= wrAddr;
        opData   <= wrData;
        opWrite  <= ctl.isWrite;
      end
      if (ctl.step) begin
        checkAcc <= foldStep(checkAcc, curCode);
        nextAcc  <= foldStep(nextAcc, newCode);
      end
      if (ctl.finish) begin
        if (checkAcc != digest) begin
          replayErr <= 1'b1;
        end else if (opWrite) begin
          digest          <= nextAcc;
          written[opAddr] <= 1'b1;
        end
      end
    end
  end

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    replayErr |=> replayErr);

  // R7
  no_commit_on_bad_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.finish && checkAcc != digest) |=> (replayErr && digest == $past(digest)));

  // R9
  digest_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.finish) |=> (digest == $past(digest)));
endmodule

// File: rtl/replay_guard.sv
module replay_guard
  import replay_guard_pkg::*;
#(
  parameter int                WORDS      = 8,
  parameter int                DATA_W     = 16,
  parameter logic [DATA_W-1:0] EMPTY_CODE = 16'hA5C3,
  localparam int               IDX_W      = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrReq,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              fillReq,
  input  logic              flushReq,
  output logic              busy,
  output logic [IDX_W-1:0]  viewAddr,
  input  logic [DATA_W-1:0] viewData,
  output logic              replayErr
);
  walkCtl_t         ctl;
  logic [IDX_W-1:0] idx;

  replay_guard_ctrl #(.WORDS(WORDS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrReq(wrReq), .fillReq(fillReq), .flushReq(flushReq),
    .errIn(replayErr), .ctl(ctl), .idx(idx), .busy(busy)
  );

  replay_guard_dp #(.WORDS(WORDS), .DATA_W(DATA_W), .EMPTY_CODE(EMPTY_CODE), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .idx(idx), .wrAddr(wrAddr), .wrData(wrData),
    .viewData(viewData), .replayErr(replayErr)
  );

  assign viewAddr = idx;
endmodule

// File: tb/replay_guard_tb.sv
`timescale 1ns/1ps
module replay_guard_tb;
  localparam int WORDS = 8;
  localparam int DW    = 16;
  localparam int AW    = $clog2(WORDS);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrReq = 1'b0, fillReq = 1'b0, flushReq = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic          busy, replayErr;
  logic [AW-1:0] viewAddr;
  logic [DW-1:0] viewData;

  // model of cache + memory seen by the walk
  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] cData [WORDS];
  logic          cValid [WORDS];
  assign viewData = cValid[viewAddr] ? cData[viewAddr] : mem[viewAddr];

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  replay_guard u_dut (
    .clk(clk), .rstN(rstN), .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData),
    .fillReq(fillReq), .flushReq(flushReq), .busy(busy), .viewAddr(viewAddr),
    .viewData(viewData), .replayErr(replayErr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    for (int i = 0; i < WORDS; i++) begin
      mem[i] = DW'(16'h3000 + i * 16'h0111);
      cData[i] = '0;
      cValid[i] = 1'b0;
    end
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // pulse request(s) for one cycle, return number of busy cycles seen
  task automatic pulse(input bit w, input bit f, input int a, input int d, output int busyLen);
    @(negedge clk);
    wrReq = w; fillReq = f; wrAddr = AW'(a); wrData = DW'(d);
    @(negedge clk);
    wrReq = 1'b0; fillReq = 1'b0;
    busyLen = 0;
    while (busy) begin
      busyLen++;
      @(negedge clk);
    end
  endtask

  task automatic userWrite(input int a, input int d, output int busyLen);
    pulse(1'b1, 1'b0, a, d, busyLen);
    if (!replayErr) begin
      cValid[a] = 1'b1;
      cData[a]  = DW'(d);
    end
  endtask

  task automatic flushWord(input int a);
    @(negedge clk);
    flushReq = 1'b1;
    mem[a] = cData[a];
    @(negedge clk);
    flushReq = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(replayErr == 1'b0, "R1 replayErr", replayErr, 0);
  endtask

  task automatic testCleanRun();
    int len;
    bit seqOk;
    // walk order observed on viewAddr (R3)
    @(negedge clk);
    fillReq = 1'b1;
    @(negedge clk);
    fillReq = 1'b0;
    seqOk = 1'b1;
    for (int i = 0; i < WORDS; i++) begin
      if (viewAddr != AW'(i) || !busy) seqOk = 1'b0;
      @(negedge clk);
    end
    @(negedge clk);
    check(seqOk, "R3 walk order", seqOk, 1);
    check(!replayErr, "R5 fill of unwritten region", replayErr, 0);
    userWrite(1, 16'h1234, len);
    check(len == WORDS + 1, "R2 busy length on write", len, WORDS + 1);
    check(!replayErr, "R7 clean write", replayErr, 0);
    userWrite(6, 16'hBEEF, len);
    userWrite(1, 16'h0F0F, len);
    pulse(1'b0, 1'b1, 0, 0, len);
    check(len == WORDS + 1, "R2 busy length on fill", len, WORDS + 1);
    check(!replayErr, "R4 digest matches after writes", replayErr, 0);
    mem[3] = 16'hDEAD;  // unwritten word changed
    pulse(1'b0, 1'b1, 0, 0, len);
    check(!replayErr, "R5 unwritten word ignored", replayErr, 0);
  endtask

  task automatic testFlushAndDrop();
    int len;
    flushWord(6);
    check(!busy, "R9 flush starts no walk", busy, 0);
    cValid[6] = 1'b0;  // clean line dropped, memory holds same value
    pulse(1'b0, 1'b1, 0, 0, len);
    check(!replayErr, "R9 digest unchanged by flush", replayErr, 0);
    // request while busy dropped (R10)
    @(negedge clk);
    fillReq = 1'b1;
    @(negedge clk);
    fillReq = 1'b0;
    @(negedge clk);
    wrReq = 1'b1; wrAddr = AW'(2); wrData = 16'h7777;
    @(negedge clk);
    wrReq = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    check(!busy, "R10 no walk from dropped request", busy, 0);
    pulse(1'b0, 1'b1, 0, 0, len);
    check(!replayErr, "R10 dropped write not committed", replayErr, 0);
    // simultaneous write and fill: write wins, one walk only (R2)
    pulse(1'b1, 1'b1, 4, 16'h4444, len);
    cValid[4] = 1'b1; cData[4] = 16'h4444;
    @(negedge clk);
    check(len == WORDS + 1 && !busy, "R2 one walk for simultaneous requests", len, WORDS + 1);
    pulse(1'b0, 1'b1, 0, 0, len);
    check(!replayErr, "R2 write taken over fill", replayErr, 0);
  endtask

  task automatic testTamperFill();
    int len;
    doReset();
    userWrite(5, 16'h1234, len);
    flushWord(5);
    cValid[5] = 1'b0;
    mem[5] = 16'h1235;
    pulse(1'b0, 1'b1, 0, 0, len);
    check(replayErr, "R6 tampered word on fill", replayErr, 1);
    pulse(1'b0, 1'b1, 0, 0, len);
    check(len == 0, "R11 no walk after exception", len, 0);
    check(replayErr, "R11 exception sticky", replayErr, 1);
  endtask

  task automatic testReplay();
    int len;
    doReset();
    userWrite(2, 16'hAAAA, len);
    flushWord(2);
    userWrite(2, 16'hBBBB, len);
    check(!replayErr, "R8 second write clean", replayErr, 0);
    cValid[2] = 1'b0;  // invalidated, memory still holds A
    pulse(1'b0, 1'b1, 0, 0, len);
    check(replayErr, "R8 stale value detected", replayErr, 1);
  endtask

  task automatic testTamperWrite();
    int len;
    doReset();
    userWrite(1, 16'h1111, len);
    userWrite(3, 16'h3333, len);
    flushWord(3);
    cValid[3] = 1'b0;
    mem[3] = 16'h0333;
    userWrite(1, 16'h2222, len);
    check(len == WORDS + 1, "R7 write walk length", len, WORDS + 1);
    check(replayErr, "R7 write verifies before commit", replayErr, 1);
    doReset();
    check(!replayErr, "R1 reset clears exception", replayErr, 0);
  endtask

  initial begin
    testReset();
    testCleanRun();
    testFlushAndDrop();
    testTamperFill();
    testReplay();
    testTamperWrite();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule